// File: doc/BRIEF.md
# Rotating slot round-robin arbiter

This block chooses which of several requesting ports may use one address channel of a bus-matrix output port. Priority comes from a ring of slots, and each slot names one requester. The ring is searched from its current top. The first slot whose requester is active, and eligible under the QoS mask, wins. A requester named in several slots receives a larger share of grants, in proportion to the number of slots it holds. The decision is registered, so the grant seen in a cycle reflects the requests of the previous cycle.

An accepted transfer on a real grant moves the ring by one place: the top slot goes to the bottom and the others move up. When nobody is requesting, the requester in the top slot is granted by default. Using a default grant never moves the ring. While the QoS restriction is active, only requesters set in the mask can win, and default grants are suppressed. Slot contents reset to a table computed from the parameters. In programmable mode they can be rewritten through one 32-bit register port. Software reads a slot back indirectly: it first writes a select word, then observes the read port.

The request/grant/accept trio is the handshake. A grant stays on offer until the requests change. `accept_i` plays the role of the ready side, and rotation happens only on a cycle where it is high. The register port and the mode and QoS pins are plain control.

Top module: `rr_slot_arbiter`

## Requirements
- R1: After reset, `grant_o` is zero, `reg_rdata_o` is zero, slot i holds requester i mod NUM_REQ, and slot 0 is the top of the ring.
- R2: `grant_o` is one-hot or zero. It is updated on each clock edge from the requests, mask and ring state sampled at that edge. The winner is the requester of the first slot, searched from the top and wrapping, whose request is active and eligible.
- R3: When `accept_i` is high while the current grant was given to an active requester, the ring advances one slot at that edge. A winner that is not in the top slot keeps winning until its own slot has passed the top.
- R4: With all requesters active and every transfer accepted, grants follow the slot table in order. With the default 6-slot table this is 0,1,2,3,0,1, repeating, so requesters 0 and 1 get twice the share.
- R5: When no requester is eligible and QoS is off, the requester in the top slot is granted by default. Accepting a default grant leaves the ring unmoved.
- R6: While `qos_en_i` is high, only requesters with their `qos_mask_i` bit set can be granted. If none of them requests, `grant_o` becomes zero.
- R7: In programmable mode (`prog_mode_i` = 1), a register write with slot index in bits [31:24] (not 0xFF), requester number in bits [7:0] and bits [23:8] zero stores that requester in that slot. A write with nonzero bits [23:8] is dropped. A write with a slot index at or above NUM_SLOTS is dropped.
- R8: A write with 0xFF in bits [31:24] selects the slot given in bits [7:0]. From the next cycle `reg_rdata_o` shows that slot's requester in bits [7:0], with bits [31:8] zero. It shows zero if the index is at or above NUM_SLOTS.
- R9: In fixed mode (`prog_mode_i` = 0), slot writes change nothing, while select writes and readback still work.
- R10: A slot holding a requester number at or above NUM_REQ is skipped. Software may remove a requester from every slot, and that requester then never receives a grant.
- R11: With NUM_REQ = 1, the ring is bypassed. The grant is 1 when QoS is off, and otherwise the masked request, one cycle later. Register writes do nothing and reads return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_REQ | Request vector, one bit per requester |
| qos_en_i | input | 1 | QoS restriction active |
| qos_mask_i | input | NUM_REQ | Requesters eligible while QoS restricts |
| accept_i | input | 1 | Transfer on the current grant completes |
| prog_mode_i | input | 1 | 1 = programmable slots, 0 = fixed |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write word |
| grant_o | output | NUM_REQ | Registered one-hot grant |
| reg_rdata_o | output | 32 | Readback of the selected slot |

## Verification
A grant is due one clock edge after the requests, mask and QoS flag that produced it are presented. A rotation caused by `accept_i` first shows in the decision made at the following edge. A slot write or a select write shows on `reg_rdata_o` one edge after the strobe. The bench drives every input one time unit after a rising edge. Its reference model computes the next state from the values before that edge, and it compares both outputs one time unit after the next edge, so each result is checked in exactly the cycle it is due. A second instance with one requester is checked against the bypass rule on the same stimulus.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int          FIELD_W   = 8;
  localparam logic [7:0]  SEL_CODE  = 8'hFF;
  localparam int          IDX_LSB   = 24;
  typedef logic [FIELD_W-1:0] slot_t;
endpackage

// File: rtl/rrs_pick.sv
module rrs_pick
  import rrs_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int NUM_SLOTS = 6,
  localparam int HW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int RIW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_SLOTS-1:0][FIELD_W-1:0] ring_i,
  input  logic [HW-1:0]                     head_i,
  input  logic [NUM_REQ-1:0]                req_i,
  input  logic                              qos_en_i,
  input  logic [NUM_REQ-1:0]                qos_mask_i,
  output logic                              found_o,
  output logic [NUM_REQ-1:0]                win_o,
  output logic                              dflt_ok_o,
  output logic [NUM_REQ-1:0]                dflt_o
);
  logic [NUM_REQ-1:0] elig;
  slot_t              owner;
  slot_t              top;
  int                 pos;

  always_comb begin
    elig    = req_i & (qos_en_i ? qos_mask_i : {NUM_REQ{1'b1}});
    found_o = 1'b0;
    win_o   = '0;
    owner   = '0;
    pos     = 0;
    // search from the top of the ring, wrapping once
    for (int p = 0; p < NUM_SLOTS; p++) begin
      pos = int'(head_i) + p;
      if (pos >= NUM_SLOTS) pos = pos - NUM_SLOTS;
      owner = ring_i[pos];
      if (!found_o && (int'(owner) < NUM_REQ) && elig[owner[RIW-1:0]]) begin
        found_o                = 1'b1;
        win_o                  = '0;
        win_o[owner[RIW-1:0]]  = 1'b1;
      end
    end
    top       = ring_i[head_i];
    dflt_ok_o = (int'(top) < NUM_REQ);
    dflt_o    = '0;
    if (dflt_ok_o) dflt_o[top[RIW-1:0]] = 1'b1;
  end
endmodule

// File: rtl/rrs_slot_store.sv
module rrs_slot_store
  import rrs_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int NUM_SLOTS = 6,
  localparam int HW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              adv_i,
  input  logic                              prog_mode_i,
  input  logic                              reg_wr_i,
  input  logic [31:0]                       reg_wdata_i,
  output logic [NUM_SLOTS-1:0][FIELD_W-1:0] ring_o,
  output logic [HW-1:0]                     head_o,
  output logic [31:0]                       reg_rdata_o
);
  slot_t      rd_sel;
  logic [7:0] w_idx;
  logic       w_sel, w_slot;

  assign w_idx  = reg_wdata_i[IDX_LSB +: 8];
  assign w_sel  = reg_wr_i && (w_idx == SEL_CODE);
  assign w_slot = reg_wr_i && !w_sel && prog_mode_i &&
                  (int'(w_idx) < NUM_SLOTS) && (reg_wdata_i[23:8] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) ring_o[i] <= FIELD_W'(i % NUM_REQ);
      head_o <= '0;
      rd_sel <= '0;
    end else begin
      if (adv_i) head_o <= (int'(head_o) == NUM_SLOTS - 1) ? '0 : head_o + 1'b1;
      if (w_sel) rd_sel <= reg_wdata_i[FIELD_W-1:0];
      if (w_slot) ring_o[w_idx[HW-1:0]] <= reg_wdata_i[FIELD_W-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (int'(rd_sel) < NUM_SLOTS) reg_rdata_o[FIELD_W-1:0] = ring_o[rd_sel[HW-1:0]];
  end
endmodule

// File: rtl/rr_slot_arbiter.sv
module rr_slot_arbiter
  import rrs_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int NUM_SLOTS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               qos_en_i,
  input  logic [NUM_REQ-1:0] qos_mask_i,
  input  logic               accept_i,
  input  logic               prog_mode_i,
  input  logic               reg_wr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [NUM_REQ-1:0] grant_o,
  output logic [31:0]        reg_rdata_o
);
  localparam int HW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  generate
    if (NUM_REQ == 1) begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grant_o <= '0;
        else        grant_o <= qos_en_i ? (req_i & qos_mask_i) : 1'b1;
      end
      assign reg_rdata_o = '0;
    end else begin : g_ring
      logic [NUM_SLOTS-1:0][FIELD_W-1:0] ring;
      logic [HW-1:0]                     head;
      logic                              found, dflt_ok, real_q, adv;
      logic [NUM_REQ-1:0]                win, dflt, grant_d;

      assign adv = accept_i && real_q;

      rrs_slot_store #(.NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS)) store_i (
        .clk(clk), .rst_n(rst_n), .adv_i(adv), .prog_mode_i(prog_mode_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .ring_o(ring), .head_o(head), .reg_rdata_o(reg_rdata_o));

      rrs_pick #(.NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS)) pick_i (
        .ring_i(ring), .head_i(head), .req_i(req_i), .qos_en_i(qos_en_i),
        .qos_mask_i(qos_mask_i), .found_o(found), .win_o(win),
        .dflt_ok_o(dflt_ok), .dflt_o(dflt));

      always_comb begin
        if (found)                     grant_d = win;
        else if (!qos_en_i && dflt_ok) grant_d = dflt;
        else                           grant_d = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          grant_o <= '0;
          real_q  <= 1'b0;
        end else begin
          grant_o <= grant_d;
          real_q  <= found;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rrs_arb_checker.sv
module rrs_arb_checker #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_SLOTS = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REQ-1:0] req_i,
  input logic               qos_en_i,
  input logic [NUM_REQ-1:0] qos_mask_i,
  input logic               prog_mode_i,
  input logic               reg_wr_i,
  input logic [31:0]        reg_wdata_i,
  input logic [NUM_REQ-1:0] grant_o,
  input logic [31:0]        reg_rdata_o
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_qos_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    qos_en_i |=> ((grant_o & ~$past(req_i & qos_mask_i)) == '0));

  assert_qos_no_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (qos_en_i && ((req_i & qos_mask_i) == '0)) |=> (grant_o == '0));

  assert_fixed_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !prog_mode_i && (reg_wdata_i[31:24] != 8'hFF)) |=> $stable(reg_rdata_o));

  assert_oob_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && (reg_wdata_i[31:24] == 8'hFF) && (int'(reg_wdata_i[7:0]) >= NUM_SLOTS))
      |=> (reg_rdata_o == '0));

  assert_rdata_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[31:8] == '0);
endmodule

bind rr_slot_arbiter rrs_arb_checker #(.NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .qos_en_i(qos_en_i),
  .qos_mask_i(qos_mask_i), .prog_mode_i(prog_mode_i), .reg_wr_i(reg_wr_i),
  .reg_wdata_i(reg_wdata_i), .grant_o(grant_o), .reg_rdata_o(reg_rdata_o));

// File: tb/rr_slot_arbiter_tb_top.sv
`timescale 1ns/1ps
module rr_slot_arbiter_tb_top;
  localparam int N  = 4;
  localparam int NS = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0, qos_mask = '0;
  logic          qos_en = 1'b0, accept = 1'b0, prog_mode = 1'b0, reg_wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [N-1:0]  grant;
  logic [31:0]   rdata;
  logic [0:0]    grant1;
  logic [31:0]   rdata1;

  int vectors = 0, miscompares = 0, wd = 0;
  bit done = 0;

  int           m_ring[NS];
  int           m_head, m_sel;
  bit           m_real;

  always #5 clk = ~clk;

  rr_slot_arbiter #(.NUM_REQ(N), .NUM_SLOTS(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .qos_en_i(qos_en), .qos_mask_i(qos_mask),
    .accept_i(accept), .prog_mode_i(prog_mode), .reg_wr_i(reg_wr), .reg_wdata_i(wdata),
    .grant_o(grant), .reg_rdata_o(rdata));

  rr_slot_arbiter #(.NUM_REQ(1), .NUM_SLOTS(NS)) dut1_i (
    .clk(clk), .rst_n(rst_n), .req_i(req[0:0]), .qos_en_i(qos_en), .qos_mask_i(qos_mask[0:0]),
    .accept_i(accept), .prog_mode_i(prog_mode), .reg_wr_i(reg_wr), .reg_wdata_i(wdata),
    .grant_o(grant1), .reg_rdata_o(rdata1));

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung run, expected completion");
      finish_run();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model next state from current inputs, then compare after the edge
  task automatic cyc(string tag);
    bit           found = 0;
    int           win = 0;
    logic [N-1:0] g = '0;
    logic [0:0]   g1;
    int           er;
    for (int p = 0; p < NS; p++) begin
      int idx = (m_head + p) % NS;
      int r   = m_ring[idx];
      if (!found && r < N && req[r] && (!qos_en || qos_mask[r])) begin
        found = 1; win = r;
      end
    end
    if (found) g[win] = 1'b1;
    else if (!qos_en && m_ring[m_head] < N) g[m_ring[m_head]] = 1'b1;
    if (accept && m_real) m_head = (m_head + 1) % NS;
    m_real = found;
    if (reg_wr) begin
      if (wdata[31:24] == 8'hFF) m_sel = int'(wdata[7:0]);
      else if (prog_mode && int'(wdata[31:24]) < NS && wdata[23:8] == 16'h0)
        m_ring[wdata[31:24]] = int'(wdata[7:0]);
    end
    g1 = qos_en ? (req[0] & qos_mask[0]) : 1'b1;
    er = (m_sel < NS) ? m_ring[m_sel] : 0;
    @(posedge clk); #1;
    chk({tag, " grant"}, 32'(grant), 32'(g));
    chk({tag, " rdata"}, rdata, 32'(er));
    chk("R11 bypass grant", 32'(grant1), 32'(g1));
    chk("R11 bypass rdata", rdata1, 32'h0);
  endtask

  task automatic wr(string tag, logic [31:0] d);
    reg_wr = 1'b1; wdata = d;
    cyc(tag);
    reg_wr = 1'b0; wdata = '0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NS; i++) m_ring[i] = i % N;
    m_head = 0; m_sel = 0; m_real = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset grant", 32'(grant), 32'h0);
    chk("R1 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;

    // R1 and R8: read back the reset slot table
    for (int s = 0; s < NS; s++) wr("R1 table", {8'hFF, 16'h0, 8'(s)});

    // R4: all active, every transfer accepted
    req = '1; accept = 1'b1;
    for (int k = 0; k < 14; k++) cyc("R4 share");

    // R3: lone requester 2 keeps winning while its slot climbs to the top
    req = 4'b0100;
    for (int k = 0; k < 8; k++) cyc("R3 rotate");

    // R5: no requests, default grant, accept does not rotate
    req = '0;
    for (int k = 0; k < 4; k++) cyc("R5 default");
    req = 4'b1000;
    cyc("R5 after default");

    // R6: QoS restriction
    qos_en = 1'b1; qos_mask = 4'b0101; req = 4'b1010;
    for (int k = 0; k < 3; k++) cyc("R6 none eligible");
    req = '1;
    for (int k = 0; k < 6; k++) cyc("R6 eligible only");
    qos_en = 1'b0; qos_mask = '0;

    // R7: programmable writes, out of range and nonzero middle bits dropped
    accept = 1'b0; req = '0; prog_mode = 1'b1;
    wr("R7 write", {8'd2, 16'h0, 8'd3});
    wr("R7 select", {8'hFF, 16'h0, 8'd2});
    wr("R7 middle bits", {8'd2, 16'h0100, 8'd1});
    wr("R7 oob write", {8'd9, 16'h0, 8'd1});
    wr("R8 oob select", {8'hFF, 16'h0, 8'd7});
    wr("R8 select 5", {8'hFF, 16'h0, 8'd5});

    // R9: fixed mode ignores slot writes
    prog_mode = 1'b0;
    wr("R9 fixed write", {8'd5, 16'h0, 8'd3});
    cyc("R9 fixed readback");

    // R10: remove requester 1 from every slot, park a bad number in slot 3
    prog_mode = 1'b1;
    wr("R10 slot1", {8'd1, 16'h0, 8'd0});
    wr("R10 slot5", {8'd5, 16'h0, 8'd2});
    wr("R10 slot3", {8'd3, 16'h0, 8'd200});
    req = '1; accept = 1'b1;
    for (int k = 0; k < 12; k++) cyc("R10 removed");
    req = 4'b0010;
    for (int k = 0; k < 3; k++) cyc("R10 never granted");

    // R2: constrained random traffic
    for (int k = 0; k < 3000; k++) begin
      req       = N'($urandom);
      accept    = 1'($urandom % 2);
      qos_en    = ($urandom % 4) == 0;
      qos_mask  = N'($urandom);
      prog_mode = 1'($urandom % 2);
      reg_wr    = ($urandom % 3) == 0;
      case ($urandom % 3)
        0:       wdata = {8'hFF, 16'h0, 8'($urandom % 8)};
        1:       wdata = {8'($urandom % 8), 16'h0, 8'($urandom % 5)};
        default: wdata = {8'($urandom % 8), 16'($urandom % 2), 8'($urandom % 4)};
      endcase
      cyc("R2 random");
    end
    reg_wr = 1'b0;
    done = 1;
    finish_run();
  end
endmodule